// File: doc/BRIEF.md
# SCSI Target Byte Handshake Engine

This block is the target side of the asynchronous REQ/ACK handshake on a SCSI data bus. A local controller picks a direction, gives a byte count and pulses a start strobe. The engine then moves that many bytes. Toward the host, it puts each byte on the bus, waits out a setup interval, then raises REQ. From the host, it raises REQ, waits for ACK, lets the bus settle, and then captures the byte.

Every byte ends with a one-cycle done pulse. In the cycle of that pulse the controller presents the next write byte or collects the read byte. A bus-reset flag cuts the transfer short at any point, including between bytes. The engine then drops all bus drive at once and reports the abort.

The incoming ACK is brought into the clock domain through two flops. Both setup and settle intervals are derived from a clock-frequency parameter.

Top module: `scsi_hs_engine`

## Requirements
- R1: With to_host_i=1, db_o holds the byte and db_oe_o rises first. req_o rises exactly SETUP_CYC clock edges later, where SETUP_CYC = max(1, ceil(CLK_MHZ*SETUP_NS/1000)). This is 20 at the defaults.
- R2: While sending, req_o and db_oe_o fall on the same edge. That edge is the third rising edge after ack_i rises, because of the two-flop synchronizer plus one state register.
- R3: With to_host_i=0, db_oe_o stays low and req_o rises. On the (SETUP_CYC+3)-th rising edge after ack_i rises, db_i is captured into rdata_o and req_o falls.
- R4: Each byte ends with done_o high for exactly one cycle. This happens on the third rising edge after ack_i falls, and never before ack_i has fallen.
- R5: A start with count_i=N transfers exactly N bytes with N done pulses. wdata_i is sampled on the edge after the start edge, and on the edge that ends each done pulse. With count_i=0, req_o never rises and no done pulse occurs.
- R6: bus_rst_i high during a byte drops req_o and db_oe_o and ends busy_o on the next edge. aborted_o pulses for one cycle and no done pulse follows.
- R7: bus_rst_i high during the done pulse between bytes aborts the transfer before the next byte. No further REQ is raised.
- R8: After reset, req_o, db_oe_o, busy_o, done_o and aborted_o are low. busy_o is high from the edge after start_i until the transfer ends. Whenever busy_o is low, req_o and db_oe_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a transfer (taken while idle) |
| to_host_i | input | 1 | 1: send bytes to host, 0: receive from host |
| count_i | input | CNT_W | Number of bytes in the transfer |
| wdata_i | input | 8 | Byte to send |
| rdata_o | output | 8 | Last byte received |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle pulse per completed byte |
| aborted_o | output | 1 | One-cycle pulse when the bus-reset flag ended the transfer |
| bus_rst_i | input | 1 | Bus-reset flag, aborts any wait |
| ack_i | input | 1 | ACK from host, asynchronous |
| req_o | output | 1 | REQ to host |
| db_i | input | 8 | Data bus in |
| db_o | output | 8 | Data bus out |
| db_oe_o | output | 1 | Data bus drive enable |

## Verification
The bench counts edges from data drive to REQ, and from each ACK change to REQ release and to done. It does this for several byte values in both directions. This catches an engine that raises REQ together with the data, that samples the bus on the ACK edge itself, or that skips a synchronizer stage. On receive, the bus value is changed right after REQ falls, so a late sample returns the wrong byte. Block transfers of zero to four bytes use a different byte at each position. This exposes an off-by-one count or a write byte latched one pulse late. The bus-reset flag is raised during setup, during the ACK wait, during the release wait and in the gap between bytes. In each case the bench checks that drive drops at once, that aborted pulses, and that no stray done or extra REQ follows.

// File: rtl/scsi_hs_pkg.sv
package scsi_hs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_SETUP,
    ST_TX_ACK,
    ST_RX_ACK,
    ST_SAMPLE,
    ST_REL
  } hs_state_e;

  function automatic int ns_to_cycles(input int clk_mhz, input int ns);
    int raw;
    raw = (clk_mhz * ns + 999) / 1000;
    return (raw < 1) ? 1 : raw;
  endfunction
endpackage

// File: rtl/scsi_hs_sync.sv
module scsi_hs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/scsi_hs_timer.sv
module scsi_hs_timer #(
  parameter int LIMIT = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic exp_o
);
  localparam int TW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
  localparam logic [TW-1:0] LAST = TW'(LIMIT - 1);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign exp_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/scsi_hs_engine.sv
module scsi_hs_engine
  import scsi_hs_pkg::*;
#(
  parameter int CLK_MHZ  = 200,
  parameter int SETUP_NS = 100,
  parameter int CNT_W    = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             to_host_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [7:0]       wdata_i,
  output logic [7:0]       rdata_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             aborted_o,
  input  logic             bus_rst_i,
  input  logic             ack_i,
  output logic             req_o,
  input  logic [7:0]       db_i,
  output logic [7:0]       db_o,
  output logic             db_oe_o
);
  localparam int SETUP_CYC = ns_to_cycles(CLK_MHZ, SETUP_NS);

  hs_state_e        state_q;
  logic [CNT_W-1:0] left_q;
  logic             dir_q;
  logic             ack_s;
  logic             tmr_run;
  logic             tmr_exp;

  scsi_hs_sync #(.STAGES(2)) u_ack_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (ack_i),
    .q_o    (ack_s)
  );

  assign tmr_run = (state_q == ST_SETUP) || (state_q == ST_SAMPLE);

  scsi_hs_timer #(.LIMIT(SETUP_CYC)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (tmr_run),
    .exp_o  (tmr_exp)
  );

  assign busy_o = (state_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      left_q    <= '0;
      dir_q     <= 1'b0;
      req_o     <= 1'b0;
      db_oe_o   <= 1'b0;
      db_o      <= '0;
      rdata_o   <= '0;
      done_o    <= 1'b0;
      aborted_o <= 1'b0;
    end else begin
      done_o    <= 1'b0;
      aborted_o <= 1'b0;
      if (state_q != ST_IDLE && bus_rst_i) begin
        state_q   <= ST_IDLE;
        req_o     <= 1'b0;
        db_oe_o   <= 1'b0;
        aborted_o <= 1'b1;
      end else begin
        unique case (state_q)
          ST_IDLE: if (start_i) begin
            left_q  <= count_i;
            dir_q   <= to_host_i;
            state_q <= ST_LOAD;
          end
          ST_LOAD: begin
            if (left_q == '0) begin
              state_q <= ST_IDLE;
            end else begin
              left_q <= left_q - 1'b1;
              if (dir_q) begin
                db_o    <= wdata_i;
                db_oe_o <= 1'b1;
                state_q <= ST_SETUP;
              end else begin
                req_o   <= 1'b1;
                state_q <= ST_RX_ACK;
              end
            end
          end
          ST_SETUP: if (tmr_exp) begin
            req_o   <= 1'b1;
            state_q <= ST_TX_ACK;
          end
          ST_TX_ACK: if (ack_s) begin
            // data and REQ released on the same edge
            req_o   <= 1'b0;
            db_oe_o <= 1'b0;
            state_q <= ST_REL;
          end
          ST_RX_ACK: if (ack_s) state_q <= ST_SAMPLE;
          ST_SAMPLE: if (tmr_exp) begin
            rdata_o <= db_i;
            req_o   <= 1'b0;
            state_q <= ST_REL;
          end
          ST_REL: if (!ack_s) begin
            done_o  <= 1'b1;
            state_q <= ST_LOAD;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  p_setup_first_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(req_o) && dir_q) |-> $past(db_oe_o));
  p_release_pair_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(db_oe_o) |-> !req_o);
  p_rx_no_drive_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !dir_q) |-> !db_oe_o);
  p_done_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_abort_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aborted_o |-> (!req_o && !db_oe_o && !busy_o && !done_o));
  p_idle_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!req_o && !db_oe_o));
endmodule

// File: tb/scsi_hs_engine_test.sv
`timescale 1ns/1ps
module scsi_hs_engine_test;
  localparam int LIM = (200 * 100 + 999) / 1000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0, to_host = 1'b0, bus_rst = 1'b0, ack = 1'b0;
  logic [7:0] count = '0, wdata = '0, db_in = '0;
  logic [7:0] rdata, db_out;
  logic       busy, done, aborted, req, db_oe;

  int n_tests = 0, n_fail = 0, n_done = 0, n_abort = 0;

  always #2.5 clk = ~clk;

  scsi_hs_engine uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .to_host_i(to_host),
    .count_i(count), .wdata_i(wdata), .rdata_o(rdata), .busy_o(busy),
    .done_o(done), .aborted_o(aborted), .bus_rst_i(bus_rst), .ack_i(ack),
    .req_o(req), .db_i(db_in), .db_o(db_out), .db_oe_o(db_oe)
  );

  always @(negedge clk) begin
    if (done) n_done++;
    if (aborted) n_abort++;
  end

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic go(input logic dir, input int n);
    @(negedge clk);
    start = 1'b1; to_host = dir; count = 8'(n);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic host_tx(input logic [7:0] exp_b, input logic [7:0] next_w);
    int k;
    k = 0;
    while (!db_oe && k < 200) begin @(negedge clk); k++; end
    chk(db_out == exp_b, "R1 data", db_out, exp_b);
    chk(!req, "R1 req before setup", req, 0);
    k = 0;
    while (!req && k < 200) begin @(negedge clk); k++; end
    chk(k == LIM, "R1 setup cycles", k, LIM);
    chk(db_oe, "R1 oe at req", db_oe, 1);
    ack = 1'b1;
    k = 0;
    do begin @(negedge clk); k++; end while (req && k < 200);
    chk(k == 3, "R2 release latency", k, 3);
    chk(!db_oe, "R2 oe with req", db_oe, 0);
    @(negedge clk);
    chk(!done, "R4 no done with ack high", done, 0);
    ack = 1'b0;
    k = 0;
    do begin @(negedge clk); k++; end while (!done && k < 200);
    chk(k == 3, "R4 done latency", k, 3);
    wdata = next_w;
    @(negedge clk);
    chk(!done, "R4 done one cycle", done, 0);
  endtask

  task automatic host_rx(input logic [7:0] val);
    int k;
    k = 0;
    while (!req && k < 200) begin @(negedge clk); k++; end
    chk(req, "R3 req raised", req, 1);
    chk(!db_oe, "R3 no drive", db_oe, 0);
    db_in = val; ack = 1'b1;
    k = 0;
    do begin @(negedge clk); k++; end while (req && k < 200);
    chk(k == LIM + 3, "R3 sample latency", k, LIM + 3);
    db_in = ~val;
    chk(rdata == val, "R3 rdata", rdata, val);
    ack = 1'b0;
    k = 0;
    do begin @(negedge clk); k++; end while (!done && k < 200);
    chk(k == 3, "R4 done latency rx", k, 3);
    chk(rdata == val, "R3 rdata held", rdata, val);
    @(negedge clk);
    chk(!done, "R4 done one cycle rx", done, 0);
  endtask

  task automatic idle_check(input string r);
    repeat (2) @(negedge clk);
    chk(!busy && !req && !db_oe, r, {busy, req, db_oe}, 0);
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] pat [6];
    int d0, a0;
    pat = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h01, 8'h80};
    repeat (3) @(negedge clk);
    chk({req, db_oe, busy, done, aborted} == 5'b0, "R8 reset state",
        {req, db_oe, busy, done, aborted}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // single bytes to host
    foreach (pat[i]) begin
      d0 = n_done;
      wdata = pat[i];
      go(1'b1, 1);
      chk(busy, "R8 busy during transfer", busy, 1);
      host_tx(pat[i], 8'h00);
      idle_check("R8 idle after tx");
      chk(n_done - d0 == 1, "R5 one done tx", n_done - d0, 1);
    end

    // single bytes from host
    foreach (pat[i]) begin
      d0 = n_done;
      go(1'b0, 1);
      host_rx(pat[i]);
      idle_check("R8 idle after rx");
      chk(n_done - d0 == 1, "R5 one done rx", n_done - d0, 1);
    end

    // block transfers, both directions
    for (int n = 1; n <= 4; n++) begin
      d0 = n_done;
      wdata = 8'((n * 37) & 8'hFF);
      go(1'b1, n);
      for (int b = 0; b < n; b++)
        host_tx(8'((n * 37 + b * 11) & 8'hFF), 8'((n * 37 + (b + 1) * 11) & 8'hFF));
      idle_check("R5 idle after block tx");
      chk(n_done - d0 == n, "R5 block tx count", n_done - d0, n);
      d0 = n_done;
      go(1'b0, n);
      for (int b = 0; b < n; b++) host_rx(8'((n * 53 + b * 29) & 8'hFF));
      idle_check("R5 idle after block rx");
      chk(n_done - d0 == n, "R5 block rx count", n_done - d0, n);
    end

    // zero count
    begin
      int seen;
      seen = 0;
      d0 = n_done;
      go(1'b1, 0);
      repeat (6) begin @(negedge clk); if (req || db_oe) seen++; end
      chk(seen == 0, "R5 zero count no req", seen, 0);
      chk(n_done == d0, "R5 zero count no done", n_done - d0, 0);
      chk(!busy, "R5 zero count idle", busy, 0);
    end

    // abort during setup
    d0 = n_done; a0 = n_abort;
    wdata = 8'h3C;
    go(1'b1, 2);
    while (!db_oe) @(negedge clk);
    repeat (3) @(negedge clk);
    bus_rst = 1'b1;
    @(negedge clk);
    chk(aborted && !req && !db_oe && !busy, "R6 abort in setup",
        {aborted, req, db_oe, busy}, 8);
    bus_rst = 1'b0;
    repeat (4) @(negedge clk);
    chk(n_abort - a0 == 1 && n_done == d0, "R6 abort pulse only", n_abort - a0, 1);

    // abort while waiting for ACK on receive
    d0 = n_done; a0 = n_abort;
    go(1'b0, 1);
    while (!req) @(negedge clk);
    repeat (5) @(negedge clk);
    bus_rst = 1'b1;
    @(negedge clk);
    chk(aborted && !req && !busy, "R6 abort in ack wait", {aborted, req, busy}, 4);
    bus_rst = 1'b0;
    repeat (4) @(negedge clk);
    chk(n_done == d0 && n_abort - a0 == 1, "R6 no done after rx abort", n_done - d0, 0);

    // abort while waiting for ACK release
    d0 = n_done; a0 = n_abort;
    wdata = 8'hC3;
    go(1'b1, 1);
    while (!req) @(negedge clk);
    ack = 1'b1;
    while (req) @(negedge clk);
    repeat (2) @(negedge clk);
    bus_rst = 1'b1;
    @(negedge clk);
    chk(aborted && !busy, "R6 abort in release wait", {aborted, busy}, 2);
    bus_rst = 1'b0;
    ack = 1'b0;
    repeat (6) @(negedge clk);
    chk(n_done == d0, "R6 no done after release abort", n_done - d0, 0);

    // abort between bytes
    begin
      int seen;
      d0 = n_done; a0 = n_abort;
      wdata = 8'h11;
      go(1'b1, 3);
      while (!req) @(negedge clk);
      ack = 1'b1;
      while (req) @(negedge clk);
      ack = 1'b0;
      while (!done) @(negedge clk);
      bus_rst = 1'b1;
      @(negedge clk);
      chk(aborted && !busy, "R7 abort between bytes", {aborted, busy}, 2);
      bus_rst = 1'b0;
      seen = 0;
      repeat (LIM + 10) begin @(negedge clk); if (req || db_oe) seen++; end
      chk(seen == 0, "R7 no next byte", seen, 0);
      chk(n_done - d0 == 1, "R7 done count", n_done - d0, 1);
    end

    // engine still works after aborts
    wdata = 8'h96;
    go(1'b1, 1);
    host_tx(8'h96, 8'h00);
    idle_check("R8 idle after recovery");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule